// File: doc/BRIEF.md
# Character Console Port

This block lets a processor exchange single characters with a keyboard-like source and a display-like sink. It sits on the processor's load/store bus in an address window that holds no memory. Each direction has a status register with a ready flag and a data register. An arriving character is latched into the input data register and raises the input ready flag. Reading that data register consumes the character and drops the flag.

Writing the output data register hands a character to the display side and drops the output ready flag. The flag comes back after a configurable display latency. A control register holds one interrupt enable per direction. The single interrupt request line stays high while any enabled direction is ready, and it drops once software services the matching data register. A sticky overrun flag records an input character that replaced one not yet read.

Top module: `char_io_port`

## Requirements
- R1: After reset, input status (offset 0) reads 0, output status (offset 2) reads 0x08 (output ready), control (offset 4) reads 0 and irq is low.
- R2: A cycle with kbd_valid high stores kbd_char in the input data register (offset 1) and sets bit 3 of the input status register.
- R3: A bus read of offset 1 returns the stored character and clears input status bit 3 from the next cycle on, unless kbd_valid is high in that same cycle.
- R4: A character arriving while input bit 3 is already set, with no read of offset 1 in that cycle, sets the sticky overrun bit 4 of the input status register. A read of offset 0 returns it and then clears it.
- R5: A character arriving in the same cycle as a read of offset 1 leaves bit 3 set, does not set overrun, and becomes the new stored character. The read in that cycle returns the old character.
- R6: A bus write of offset 3 clears output status bit 3 in the next cycle and drives the written value on disp_char with disp_strobe high for exactly that one cycle.
- R7: Output status bit 3 reads 1 again exactly DISP_LAT cycles after the clock edge that accepted the write of offset 3.
- R8: Control register (offset 4) bit 2 is the input interrupt enable and bit 1 is the output interrupt enable. Both read back as written, and all other control bits read 0.
- R9: irq is high exactly when (input ready and bit 2) or (output ready and bit 1).
- R10: Reads of offsets 5 to 7 return 0. Writes to offsets 0, 1, 2 and 5 to 7 change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access targets this block |
| bus_rd | input | 1 | Load access |
| bus_wr | input | 1 | Store access |
| bus_addr | input | AW | Register offset |
| bus_wdata | input | DW | Store data |
| bus_rdata | output | DW | Load data, combinational from offset |
| kbd_valid | input | 1 | A new input character is present this cycle |
| kbd_char | input | DW | Input character |
| disp_char | output | DW | Last character written for display |
| disp_strobe | output | 1 | One-cycle pulse, disp_char is new |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the effect of each event on the flags one cycle later. A character sets input ready, a plain data read clears it, an output write clears output ready and pulses the strobe, and overrun holds until a status read. They also check that irq stays low with both enables off. The exact display latency, read-back values, the mixed read/arrival cycle, undefined offsets and the full irq equation are shown only by the bench's scenarios, which compare them with a reference model.

// File: rtl/char_io_pkg.sv
package char_io_pkg;
  localparam int OFS_IN_STAT  = 0;
  localparam int OFS_IN_DATA  = 1;
  localparam int OFS_OUT_STAT = 2;
  localparam int OFS_OUT_DATA = 3;
  localparam int OFS_CTRL     = 4;
  localparam int RDY_BIT      = 3;
  localparam int OVR_BIT      = 4;
  localparam int IEN_IN_BIT   = 2;
  localparam int IEN_OUT_BIT  = 1;
endpackage

// File: rtl/cio_reset_sync.sv
module cio_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], 1'b1};
  end
  assign rst_q_n = sr[STAGES-1];
endmodule

// File: rtl/cio_in_chan.sv
module cio_in_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_vld,
  input  logic [DW-1:0] dev_char,
  input  logic          rd_data_p,
  input  logic          rd_stat_p,
  output logic          rdy,
  output logic          ovr,
  output logic [DW-1:0] data
);
  logic          rdy_n, ovr_n;
  logic [DW-1:0] data_n;
  logic          data_en;

  always_comb begin
    rdy_n = rdy;
    if (rd_data_p) rdy_n = 1'b0;
    if (dev_vld)   rdy_n = 1'b1;
    ovr_n = ovr;
    if (rd_stat_p) ovr_n = 1'b0;
    if (dev_vld && rdy && !rd_data_p) ovr_n = 1'b1;
    data_en = dev_vld;
    data_n  = dev_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= 1'b0;
      ovr <= 1'b0;
    end else begin
      rdy <= rdy_n;
      ovr <= ovr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data <= '0;
    else if (data_en) data <= data_n;
  end
endmodule

// File: rtl/cio_out_chan.sv
module cio_out_chan #(
  parameter int DW  = 8,
  parameter int LAT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_p,
  input  logic [DW-1:0] wdata,
  output logic          rdy,
  output logic [DW-1:0] disp_char,
  output logic          disp_strobe
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

  logic [CW-1:0] cnt, cnt_n;
  logic          rdy_n, cnt_en;

  always_comb begin
    rdy_n  = rdy;
    cnt_n  = cnt;
    cnt_en = 1'b0;
    if (wr_p) begin
      rdy_n  = 1'b0;
      cnt_n  = LOAD;
      cnt_en = 1'b1;
    end else if (!rdy) begin
      if (cnt == '0) rdy_n = 1'b1;
      else begin
        cnt_n  = cnt - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy         <= 1'b1;
      disp_strobe <= 1'b0;
    end else begin
      rdy         <= rdy_n;
      disp_strobe <= wr_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    disp_char <= '0;
    else if (wr_p) disp_char <= wdata;
  end
endmodule

// File: rtl/cio_regs.sv
module cio_regs
  import char_io_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          in_rdy,
  input  logic          in_ovr,
  input  logic [DW-1:0] in_data,
  input  logic          out_rdy,
  output logic [DW-1:0] rdata,
  output logic          rd_data_p,
  output logic          rd_stat_p,
  output logic          wr_out_p,
  output logic          ien_in,
  output logic          ien_out,
  output logic          irq
);
  localparam logic [AW-1:0] A_IN_STAT  = AW'(OFS_IN_STAT);
  localparam logic [AW-1:0] A_IN_DATA  = AW'(OFS_IN_DATA);
  localparam logic [AW-1:0] A_OUT_STAT = AW'(OFS_OUT_STAT);
  localparam logic [AW-1:0] A_OUT_DATA = AW'(OFS_OUT_DATA);
  localparam logic [AW-1:0] A_CTRL     = AW'(OFS_CTRL);

  logic ctrl_we;
  logic ien_in_n, ien_out_n;

  always_comb begin
    rd_data_p = sel && rd && (addr == A_IN_DATA);
    rd_stat_p = sel && rd && (addr == A_IN_STAT);
    wr_out_p  = sel && wr && (addr == A_OUT_DATA);
    ctrl_we   = sel && wr && (addr == A_CTRL);
    ien_in_n  = wdata[IEN_IN_BIT];
    ien_out_n = wdata[IEN_OUT_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_in  <= 1'b0;
      ien_out <= 1'b0;
    end else if (ctrl_we) begin
      ien_in  <= ien_in_n;
      ien_out <= ien_out_n;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_IN_STAT: begin
        rdata[RDY_BIT] = in_rdy;
        rdata[OVR_BIT] = in_ovr;
      end
      A_IN_DATA:  rdata = in_data;
      A_OUT_STAT: rdata[RDY_BIT] = out_rdy;
      A_CTRL: begin
        rdata[IEN_IN_BIT]  = ien_in;
        rdata[IEN_OUT_BIT] = ien_out;
      end
      default: rdata = '0;
    endcase
  end

  assign irq = (in_rdy && ien_in) || (out_rdy && ien_out);
endmodule

// File: rtl/char_io_port.sv
module char_io_port #(
  parameter int AW       = 3,
  parameter int DW       = 8,
  parameter int DISP_LAT = 5,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          kbd_valid,
  input  logic [DW-1:0] kbd_char,
  output logic [DW-1:0] disp_char,
  output logic          disp_strobe,
  output logic          irq
);
  logic          rst_q_n;
  logic          in_rdy, in_ovr, out_rdy;
  logic [DW-1:0] in_data;
  logic          rd_data_p, rd_stat_p, wr_out_p;
  logic          ien_in, ien_out;

  cio_reset_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  cio_in_chan #(.DW(DW)) u_in (
    .clk(clk), .rst_n(rst_q_n), .dev_vld(kbd_valid), .dev_char(kbd_char),
    .rd_data_p(rd_data_p), .rd_stat_p(rd_stat_p),
    .rdy(in_rdy), .ovr(in_ovr), .data(in_data)
  );

  cio_out_chan #(.DW(DW), .LAT(DISP_LAT)) u_out (
    .clk(clk), .rst_n(rst_q_n), .wr_p(wr_out_p), .wdata(bus_wdata),
    .rdy(out_rdy), .disp_char(disp_char), .disp_strobe(disp_strobe)
  );

  cio_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .sel(bus_sel), .rd(bus_rd), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .in_rdy(in_rdy), .in_ovr(in_ovr),
    .in_data(in_data), .out_rdy(out_rdy), .rdata(bus_rdata),
    .rd_data_p(rd_data_p), .rd_stat_p(rd_stat_p), .wr_out_p(wr_out_p),
    .ien_in(ien_in), .ien_out(ien_out), .irq(irq)
  );
endmodule

// File: rtl/char_io_port_chk.sv
module char_io_port_chk (
  input logic clk,
  input logic rst_q_n,
  input logic kbd_valid,
  input logic rd_data_p,
  input logic rd_stat_p,
  input logic wr_out_p,
  input logic in_rdy,
  input logic in_ovr,
  input logic out_rdy,
  input logic disp_strobe,
  input logic ien_in,
  input logic ien_out,
  input logic irq
);
  AST_IN_SET: assert property (@(posedge clk) disable iff (!rst_q_n)
    kbd_valid |=> in_rdy); // R2
  AST_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_data_p && !kbd_valid) |=> !in_rdy); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_ovr && !rd_stat_p) |=> in_ovr); // R4
  AST_OUT_BUSY: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_out_p |=> (!out_rdy && disp_strobe)); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ien_in && !ien_out) |-> !irq); // R9
endmodule

bind char_io_port char_io_port_chk u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .kbd_valid(kbd_valid),
  .rd_data_p(rd_data_p), .rd_stat_p(rd_stat_p), .wr_out_p(wr_out_p),
  .in_rdy(in_rdy), .in_ovr(in_ovr), .out_rdy(out_rdy),
  .disp_strobe(disp_strobe), .ien_in(ien_in), .ien_out(ien_out), .irq(irq)
);

// File: tb/sim_char_io_port.sv
`timescale 1ns/1ps
module sim_char_io_port;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic kbd_valid = 1'b0;
  logic [DW-1:0] kbd_char = '0;
  logic [DW-1:0] disp_char;
  logic disp_strobe, irq;

  int total = 0, bad = 0;
  bit m_rdy, m_ovr, m_ien_in, m_ien_out;
  bit m_out_rdy;
  logic [DW-1:0] m_dat;

  always #5 clk = ~clk;

  char_io_port #(.AW(AW), .DW(DW), .DISP_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .kbd_valid(kbd_valid), .kbd_char(kbd_char),
    .disp_char(disp_char), .disp_strobe(disp_strobe), .irq(irq)
  );

  function automatic logic [DW-1:0] exp_instat();
    return {3'b0, m_ovr, m_rdy, 3'b0};
  endfunction

  function automatic bit exp_irq();
    return (m_rdy && m_ien_in) || (m_out_rdy && m_ien_out);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = AW'(a);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic bus_write(input int a, input logic [DW-1:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic push(input logic [DW-1:0] c);
    @(negedge clk);
    kbd_valid = 1'b1; kbd_char = c;
    @(negedge clk);
    kbd_valid = 1'b0;
    if (m_rdy) m_ovr = 1'b1;
    m_rdy = 1'b1; m_dat = c;
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd1234));
    m_rdy = 0; m_ovr = 0; m_ien_in = 0; m_ien_out = 0; m_out_rdy = 1; m_dat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(0, d); chk(d == 8'h00, "R1 in status", d, 0);
    bus_read(2, d); chk(d == 8'h08, "R1 out status", d, 8);
    bus_read(4, d); chk(d == 8'h00, "R1 control", d, 0);
    #1 chk(irq == 1'b0, "R1 irq", irq, 0);

    // R10 undefined offsets and ignored writes
    for (int a = 5; a < 8; a++) begin
      bus_write(a, 8'hFF);
      bus_read(a, d); chk(d == 8'h00, "R10 undefined read", d, 0);
    end
    bus_write(0, 8'hFF); bus_write(1, 8'hA5); bus_write(2, 8'h00);
    bus_read(0, d); chk(d == 8'h00, "R10 in status unchanged", d, 0);
    bus_read(1, d); chk(d == 8'h00, "R10 in data unchanged", d, 0);
    bus_read(2, d); chk(d == 8'h08, "R10 out status unchanged", d, 8);

    // R2 / R3 basic input
    push(8'h41);
    bus_read(0, d); chk(d == exp_instat(), "R2 ready set", d, exp_instat());
    bus_read(1, d); chk(d == 8'h41, "R3 data value", d, 8'h41); m_rdy = 0;
    bus_read(0, d); chk(d == 8'h00, "R3 ready cleared", d, 0);

    // R4 overrun
    push(8'h10); push(8'h11);
    bus_read(0, d); chk(d == 8'h18, "R4 overrun seen", d, 8'h18); m_ovr = 0;
    bus_read(0, d); chk(d == 8'h08, "R4 overrun cleared by read", d, 8'h08);
    bus_read(1, d); chk(d == 8'h11, "R4 newest char kept", d, 8'h11); m_rdy = 0;

    // R5 arrival during data read
    push(8'h20);
    @(negedge clk);
    kbd_valid = 1'b1; kbd_char = 8'h21;
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 3'd1;
    #1 d = bus_rdata; chk(d == 8'h20, "R5 read returns old", d, 8'h20);
    @(negedge clk);
    kbd_valid = 1'b0; bus_sel = 1'b0; bus_rd = 1'b0;
    m_dat = 8'h21; m_rdy = 1; m_ovr = 0;
    bus_read(0, d); chk(d == 8'h08, "R5 ready kept no overrun", d, 8'h08);
    bus_read(1, d); chk(d == 8'h21, "R5 new char", d, 8'h21); m_rdy = 0;

    // R8 control register
    bus_write(4, 8'hFF); m_ien_in = 1; m_ien_out = 1;
    bus_read(4, d); chk(d == 8'h06, "R8 control readback", d, 6);
    #1 chk(irq == exp_irq(), "R9 irq out ready", irq, exp_irq());
    bus_write(4, 8'h00); m_ien_in = 0; m_ien_out = 0;
    #1 chk(irq == 1'b0, "R9 irq disabled", irq, 0);

    // R6 / R7 output path with latency
    bus_write(3, 8'h5A);
    #1 chk(disp_strobe == 1'b1 && disp_char == 8'h5A, "R6 strobe and char", disp_char, 8'h5A);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 3'd2;
    for (int k = 1; k <= LAT + 1; k++) begin
      if (k > 1) @(negedge clk);
      #1;
      if (k == 2) chk(disp_strobe == 1'b0, "R6 strobe one cycle", disp_strobe, 0);
      chk(bus_rdata == ((k > LAT) ? 8'h08 : 8'h00), "R7 out ready timing",
          bus_rdata, (k > LAT) ? 8 : 0);
    end
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;

    // random mix, R2 R3 R4 R8 R9
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: push(8'($urandom()));
        1: begin
          bus_read(1, d); chk(d == m_dat, "R3 random data", d, m_dat); m_rdy = 0;
        end
        2: begin
          bus_read(0, d); chk(d == exp_instat(), "R4 random status", d, exp_instat());
          m_ovr = 0;
        end
        3: begin
          logic [DW-1:0] v;
          v = 8'($urandom());
          bus_write(4, v); m_ien_in = v[2]; m_ien_out = v[1];
          bus_read(4, d); chk(d == (v & 8'h06), "R8 random control", d, v & 8'h06);
        end
        default: begin
          @(negedge clk);
          #1 chk(irq == exp_irq(), "R9 random irq", irq, exp_irq());
        end
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule